// File: doc/BRIEF.md
# Dual-Issue Register Alias Checker

The checker takes two consecutive instruction words, `insn_a_i` (older) and `insn_b_i` (younger). It decides whether the younger word may issue in the same cycle as the older one.

The destination register does not sit in a fixed place; its position depends on the encoding block. Each word is therefore classified first. The block class then enables the register comparisons that apply. When both blocks are recognised, full 6-bit register numbers are compared. When either word falls outside the known patterns, the checker compares the low nibble of every field that could hold a register, and rejects any possible match.

The decision, both block classes and the older word's decoded destination are registered. They appear one clock after the inputs are sampled.

Word layout used throughout: bits [31:16] form the leading halfword and bits [15:0] the trailing halfword.

Register numbers are built from three candidate fields, each with its extension bits:
- Field P: `{~w[31], w[10], w[23:20]}`
- Field Q: `{~w[30], w[9], w[19:16]}`
- Field S: `{~w[29], w[8], w[7:4]}`

The top-field bits are stored inverted, so the all-ones prefix gives extension bit 0.

Top module: `dic_pair_check`

## Requirements
- R1: A word is 32-bit only when w[31:29] = 111. Otherwise its class code is 0 and `pair_ok_o` is 0.
- R2: `dst_a_o` reports the older word's 6-bit destination number. It is 0 for class codes 0 and 5.
- R3: Class 1 (three-register) applies when w[27]=0 and w[25:24]=00 and the R4 pattern is absent. The destination is field P; fields Q and S are sources.
- R4: Class 2 (one-register) applies when w[27]=0, w[25:24]=00, w[15:12]=0011 and w[3:0]=0000. Its only register is field S, treated as the destination.
- R5: Class 3 (two-register) applies when w[27]=0 and w[25:24]≠00. The destination is field P and the only source is field Q; bits [7:4] are not a register.
- R6: Class 4 (immediate-destination) applies when w[27]=1 and w[25:24]=00. The destination is `{~w[31], w[20], w[19:16]}`, and the word has no sources.
- R7: Class 5 (unrecognised) applies when w[27]=1 and w[25:24]≠00. If either word is class 5, the pair is rejected when any of the low nibbles w[23:20], w[19:16], w[7:4] of the older word equals any of the same three nibbles of the younger word.
- R8: When both words are in classes 1 to 4, the full 6-bit numbers are compared. Registers that differ only in an extension bit do not alias.
- R9: With both words in classes 1 to 4, the pair is rejected when the older destination equals any enabled source or the destination of the younger word.
- R10: All outputs are registered with one cycle of latency, and reset to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| insn_a_i | input | 32 | Older instruction word |
| insn_b_i | input | 32 | Younger instruction word |
| pair_ok_o | output | 1 | Younger word may dual-issue |
| blk_a_o | output | 3 | Class code of older word |
| blk_b_o | output | 3 | Class code of younger word |
| dst_a_o | output | 6 | Decoded destination of older word |

## Verification
Every result is due exactly one rising edge after the input pair is presented: the decision, both class codes and the decoded destination.

Each directed task drives a pair on the falling edge, waits for the next rising edge and samples 1 ns after it. Each sample therefore reflects only that pair.

A separate check changes the inputs mid-cycle and confirms the outputs still hold the previous result until the next rising edge.

// File: rtl/dic_pkg.sv
package dic_pkg;
  localparam int INSN_W   = 32;
  localparam int REG_W    = 6;
  localparam int LOW_W    = 4;
  localparam int NUM_CAND = 3;
  localparam int NUM_HIT  = NUM_CAND * NUM_CAND;
  localparam int BLK_W    = 3;

  typedef enum logic [BLK_W-1:0] {
    BLK_SHORT = 3'd0,
    BLK_3R    = 3'd1,
    BLK_1R    = 3'd2,
    BLK_2R    = 3'd3,
    BLK_IMM   = 3'd4,
    BLK_UNK   = 3'd5
  } blk_e;

  typedef struct packed {
    blk_e                            blk;
    logic [REG_W-1:0]                dst;
    logic [REG_W-1:0]                src0;
    logic [REG_W-1:0]                src1;
    logic                            dst_en;
    logic                            src0_en;
    logic                            src1_en;
    logic [NUM_CAND-1:0][LOW_W-1:0]  cand;
  } dec_t;
endpackage

// File: rtl/dic_decode.sv
module dic_decode
  import dic_pkg::*;
(
  input  logic [INSN_W-1:0] insn_i,
  output dec_t              dec_o
);
  logic             wide;
  logic             is_one_reg;
  logic [REG_W-1:0] fld_p, fld_q, fld_s, fld_imm;

  assign wide       = (insn_i[31:29] == 3'b111);
  assign is_one_reg = (insn_i[15:12] == 4'b0011) && (insn_i[3:0] == 4'b0000);
  // high bit stored inverted in the prefix field
  assign fld_p   = {~insn_i[31], insn_i[10], insn_i[23:20]};
  assign fld_q   = {~insn_i[30], insn_i[9],  insn_i[19:16]};
  assign fld_s   = {~insn_i[29], insn_i[8],  insn_i[7:4]};
  assign fld_imm = {~insn_i[31], insn_i[20], insn_i[19:16]};

  always_comb begin
    dec_o      = '0;
    dec_o.blk  = BLK_SHORT;
    dec_o.cand = {insn_i[7:4], insn_i[19:16], insn_i[23:20]};
    if (wide) begin
      if (!insn_i[27] && insn_i[25:24] == 2'b00) begin
        if (is_one_reg) begin
          dec_o.blk    = BLK_1R;
          dec_o.dst    = fld_s;
          dec_o.dst_en = 1'b1;
        end else begin
          dec_o.blk     = BLK_3R;
          dec_o.dst     = fld_p;
          dec_o.src0    = fld_q;
          dec_o.src1    = fld_s;
          dec_o.dst_en  = 1'b1;
          dec_o.src0_en = 1'b1;
          dec_o.src1_en = 1'b1;
        end
      end else if (!insn_i[27]) begin
        dec_o.blk     = BLK_2R;
        dec_o.dst     = fld_p;
        dec_o.src0    = fld_q;
        dec_o.dst_en  = 1'b1;
        dec_o.src0_en = 1'b1;
      end else if (insn_i[25:24] == 2'b00) begin
        dec_o.blk    = BLK_IMM;
        dec_o.dst    = fld_imm;
        dec_o.dst_en = 1'b1;
      end else begin
        dec_o.blk = BLK_UNK;
      end
    end
  end
endmodule

// File: rtl/dic_compare.sv
module dic_compare
  import dic_pkg::*;
(
  input  dec_t dec_a_i,
  input  dec_t dec_b_i,
  output logic pair_ok_o
);
  logic [NUM_HIT-1:0] loose_hit;
  logic               exact_hit;
  logic               use_loose;
  logic               both_wide;

  for (genvar i = 0; i < NUM_CAND; i++) begin : g_a
    for (genvar j = 0; j < NUM_CAND; j++) begin : g_b
      assign loose_hit[i*NUM_CAND+j] = (dec_a_i.cand[i] == dec_b_i.cand[j]);
    end
  end

  assign exact_hit = dec_a_i.dst_en &&
                     ((dec_b_i.dst_en  && dec_b_i.dst  == dec_a_i.dst) ||
                      (dec_b_i.src0_en && dec_b_i.src0 == dec_a_i.dst) ||
                      (dec_b_i.src1_en && dec_b_i.src1 == dec_a_i.dst));

  assign use_loose = (dec_a_i.blk == BLK_UNK) || (dec_b_i.blk == BLK_UNK);
  assign both_wide = (dec_a_i.blk != BLK_SHORT) && (dec_b_i.blk != BLK_SHORT);
  assign pair_ok_o = both_wide && !(use_loose ? (|loose_hit) : exact_hit);
endmodule

// File: rtl/dic_pair_check.sv
module dic_pair_check
  import dic_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [INSN_W-1:0] insn_a_i,
  input  logic [INSN_W-1:0] insn_b_i,
  output logic              pair_ok_o,
  output logic [BLK_W-1:0]  blk_a_o,
  output logic [BLK_W-1:0]  blk_b_o,
  output logic [REG_W-1:0]  dst_a_o
);
  localparam int NUM_SLOT = 2;

  logic [NUM_SLOT-1:0][INSN_W-1:0] insn;
  dec_t                            dec [NUM_SLOT];
  logic                            pair_ok_d;

  assign insn[0] = insn_a_i;
  assign insn[1] = insn_b_i;

  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_dec
    dic_decode u_decode (
      .insn_i (insn[s]),
      .dec_o  (dec[s])
    );
  end

  dic_compare u_compare (
    .dec_a_i   (dec[0]),
    .dec_b_i   (dec[1]),
    .pair_ok_o (pair_ok_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pair_ok_o <= 1'b0;
      blk_a_o   <= '0;
      blk_b_o   <= '0;
      dst_a_o   <= '0;
    end else begin
      pair_ok_o <= pair_ok_d;
      blk_a_o   <= dec[0].blk;
      blk_b_o   <= dec[1].blk;
      dst_a_o   <= dec[0].dst;
    end
  end
endmodule

// File: rtl/dic_pair_check_sva.sv
module dic_pair_check_sva
  import dic_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [INSN_W-1:0] insn_a_i,
  input logic [INSN_W-1:0] insn_b_i,
  input logic              pair_ok_o,
  input logic [BLK_W-1:0]  blk_a_o,
  input logic [BLK_W-1:0]  blk_b_o,
  input logic [REG_W-1:0]  dst_a_o
);
  logic past_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  AST_SHORT_NO_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(insn_a_i[31:29] != 3'b111 || insn_b_i[31:29] != 3'b111))
      |-> !pair_ok_o); // R1

  AST_PAIR_WIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_ok_o |-> (blk_a_o != 3'd0 && blk_b_o != 3'd0)); // R1

  AST_NODST_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_a_o == 3'd0 || blk_a_o == 3'd5) |-> (dst_a_o == '0)); // R2

  AST_IMM_DST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(insn_a_i[31:29] == 3'b111 && insn_a_i[27] && insn_a_i[25:24] == 2'b00))
      |-> (blk_a_o == 3'd4 &&
           dst_a_o == {~$past(insn_a_i[31]), $past(insn_a_i[20]), $past(insn_a_i[19:16])})); // R6

  AST_SELF_ALIAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(insn_a_i == insn_b_i)) |-> !pair_ok_o); // R9
endmodule

bind dic_pair_check dic_pair_check_sva u_sva (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .insn_a_i  (insn_a_i),
  .insn_b_i  (insn_b_i),
  .pair_ok_o (pair_ok_o),
  .blk_a_o   (blk_a_o),
  .blk_b_o   (blk_b_o),
  .dst_a_o   (dst_a_o)
);

// File: tb/dic_pair_check_tb.sv
module dic_pair_check_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] insn_a_i = '0;
  logic [31:0] insn_b_i = '0;
  logic        pair_ok_o;
  logic [2:0]  blk_a_o, blk_b_o;
  logic [5:0]  dst_a_o;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done  = 1'b0;

  always #2.5 clk_i = ~clk_i;

  dic_pair_check u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .insn_a_i(insn_a_i), .insn_b_i(insn_b_i),
    .pair_ok_o(pair_ok_o), .blk_a_o(blk_a_o), .blk_b_o(blk_b_o), .dst_a_o(dst_a_o)
  );

  function automatic logic [31:0] w3r(input logic [4:0] p, q, s);
    logic [31:0] w = 32'hE000_0000;
    w[23:20] = p[3:0]; w[19:16] = q[3:0]; w[7:4] = s[3:0];
    w[10] = p[4]; w[9] = q[4]; w[8] = s[4];
    return w;
  endfunction

  function automatic logic [31:0] w1r(input logic [4:0] r);
    logic [31:0] w = 32'hE000_3000;
    w[7:4] = r[3:0]; w[8] = r[4];
    return w;
  endfunction

  function automatic logic [31:0] w2r(input logic [4:0] p, q, input logic [3:0] junk);
    logic [31:0] w = 32'hE100_0000;
    w[23:20] = p[3:0]; w[19:16] = q[3:0]; w[10] = p[4]; w[9] = q[4];
    w[7:4] = junk;
    return w;
  endfunction

  function automatic logic [31:0] wimm(input logic [4:0] r);
    logic [31:0] w = 32'hE800_0000;
    w[19:16] = r[3:0]; w[20] = r[4];
    return w;
  endfunction

  function automatic logic [31:0] wunk(input logic [3:0] f0, f1, f2);
    logic [31:0] w = 32'hE900_0000;
    w[23:20] = f0; w[19:16] = f1; w[7:4] = f2;
    return w;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [31:0] b);
    @(negedge clk_i);
    insn_a_i = a; insn_b_i = b;
    @(posedge clk_i);
    #1;
  endtask

  task automatic t_reset;
    check("R10 reset ok",  pair_ok_o, 0);
    check("R10 reset blk", blk_a_o,   0);
    check("R10 reset dst", dst_a_o,   0);
  endtask

  task automatic t_three_reg;
    apply(w3r(5, 6, 7), w3r(8, 9, 10));
    check("R3 independent ok", pair_ok_o, 1);
    check("R3 blk a", blk_a_o, 1);
    check("R3 blk b", blk_b_o, 1);
    check("R2 dst a", dst_a_o, 5);
    apply(w3r(5, 6, 7), w3r(8, 5, 10));
    check("R9 raw q", pair_ok_o, 0);
    apply(w3r(5, 6, 7), w3r(8, 9, 5));
    check("R9 raw s", pair_ok_o, 0);
    apply(w3r(5, 6, 7), w3r(5, 9, 10));
    check("R9 waw", pair_ok_o, 0);
    apply(w3r(5, 6, 7), w3r(8, 21, 10));
    check("R8 ext differs", pair_ok_o, 1);
  endtask

  task automatic t_one_reg;
    apply(w1r(12), w3r(1, 12, 2));
    check("R4 blk", blk_a_o, 2);
    check("R4 dst", dst_a_o, 12);
    check("R4 raw", pair_ok_o, 0);
    apply(w1r(12), w3r(1, 2, 3));
    check("R4 free", pair_ok_o, 1);
    apply(w3r(3, 4, 7), w1r(3));
    check("R4 b blk", blk_b_o, 2);
    check("R4 b waw", pair_ok_o, 0);
  endtask

  task automatic t_two_reg;
    apply(w2r(3, 4, 0), w2r(7, 3, 0));
    check("R5 blk", blk_a_o, 3);
    check("R5 dst", dst_a_o, 3);
    check("R5 raw", pair_ok_o, 0);
    apply(w2r(3, 4, 0), w2r(7, 8, 3));
    check("R5 junk ignored", pair_ok_o, 1);
  endtask

  task automatic t_imm;
    apply(wimm(17), w3r(1, 17, 2));
    check("R6 blk", blk_a_o, 4);
    check("R6 dst", dst_a_o, 17);
    check("R6 raw", pair_ok_o, 0);
    apply(wimm(17), w3r(1, 1, 2));
    check("R8 exact low nibble", pair_ok_o, 1);
    apply(wimm(17), wimm(17));
    check("R6 waw", pair_ok_o, 0);
  endtask

  task automatic t_unknown;
    apply(wunk(4, 5, 6), w3r(1, 2, 3));
    check("R7 blk", blk_a_o, 5);
    check("R2 unk dst", dst_a_o, 0);
    check("R7 no hit", pair_ok_o, 1);
    apply(wunk(4, 5, 6), w3r(9, 10, 6));
    check("R7 hit", pair_ok_o, 0);
    apply(wunk(4, 5, 6), w3r(20, 9, 10));
    check("R7 low nibble hit", pair_ok_o, 0);
    apply(w3r(5, 6, 7), wunk(1, 2, 7));
    check("R7 false alias", pair_ok_o, 0);
    check("R7 blk b", blk_b_o, 5);
  endtask

  task automatic t_short;
    apply(32'h0000_1234, w3r(1, 2, 3));
    check("R1 short a blk", blk_a_o, 0);
    check("R1 short a ok", pair_ok_o, 0);
    apply(w3r(1, 2, 3), 32'h6000_4567);
    check("R1 short b blk", blk_b_o, 0);
    check("R1 short b ok", pair_ok_o, 0);
  endtask

  task automatic t_latency;
    apply(w3r(5, 6, 7), w3r(8, 9, 10));
    @(negedge clk_i);
    insn_b_i = w3r(5, 9, 10);
    #1;
    check("R10 hold before edge", pair_ok_o, 1);
    @(posedge clk_i);
    #1;
    check("R10 update after edge", pair_ok_o, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    t_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_three_reg();
    t_one_reg();
    t_two_reg();
    t_imm();
    t_unknown();
    t_short();
    t_latency();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule